// File: doc/BRIEF.md
# Step-Down Regulator Operating-Mode Controller

This block is the digital controller that chooses how a synchronous step-down regulator switches. It reads a set of comparator flags: output below target, above target +2.5 %, below target −2 %, above target +15 %, light load, power-save current limit reached, peak inductor current reached, and duty cycle near 100 %. From these it picks one of these modes:

- fixed-frequency PWM;
- hysteretic power-save with switching bursts;
- pass-through, with the high-side switch held on;
- over-voltage lockout.

The analog loop, the comparators, the oscillator and the switches lie outside the block. The oscillator reaches the block as a one-cycle tick per switching period. Mode decisions are taken on that tick, except over-voltage and disable, which act at once.

The states are `M_IDLE`, `M_PWM`, `M_PASS`, `M_PS_WAIT`, `M_PS_BURST` and `M_OV_LOCK`.

- Reset or disable forces `M_IDLE`.
- An enabled `M_IDLE` moves to `M_PWM` on a tick.
- `M_PWM` goes to `M_PASS` on near-full duty, or else to `M_PS_WAIT` on light load.
- `M_PASS` returns to `M_PWM` once near-full duty clears.
- `M_PS_WAIT` goes to `M_PWM` on the −2 % flag, or else to `M_PS_BURST` when the output is below target.
- `M_PS_BURST` goes to `M_PWM` on the −2 % flag, or else back to `M_PS_WAIT` when the output is above +2.5 % or the power-save current limit is reached.
- From any enabled state, the +15 % flag forces `M_OV_LOCK` in the next clock.
- `M_OV_LOCK` leaves for `M_PWM` only on a tick that sees the −2 % flag.

Inside a burst, a high-side pulse starts on each tick and ends when peak current is reached.

Top module: `buck_mode_ctrl`

## Requirements
- R1: After reset, or in the clock after `enable` is sampled low, every output is 0. While `enable` is low, all flags and ticks are ignored.
- R2: With `enable` high and `over_ov` low, the mode outputs change only in the clock after a cycle in which `cyc_tick` was 1. An enabled idle controller enters PWM (`pwm_en`=1) on the first tick.
- R3: In PWM, a tick with `light_load`=1 (and `full_duty`=0) enters power-save. `pwm_en` drops and `ps_mode` rises.
- R4: In power-save with switching halted, a tick with `below_tgt`=1 (and `below_lo`=0) starts a burst: `burst_en`=1 and `burst_hs`=1. Without `below_tgt` the controller stays halted.
- R5: During a burst, a tick with `above_hi`=1 or `ps_ilim`=1 halts switching (`burst_en`=0, `ps_mode` stays 1).
- R6: `burst_hs` rises on each tick that keeps the burst going. It falls in the clock after `peak_hit`=1. A tick in the same cycle as `peak_hit` wins, and the pulse stays 1.
- R7: In power-save, whether halted or bursting, a tick with `below_lo`=1 returns to PWM. This takes priority over starting a burst.
- R8: With `enable` high, `over_ov`=1 in any state gives `ov_lock`=1 and all drive outputs 0 in the next clock, without waiting for a tick. This aborts any burst in progress.
- R9: `ov_lock` stays 1 until a tick with `below_lo`=1 and `over_ov`=0, which enters PWM. A tick with only `below_tgt` keeps the lock.
- R10: In PWM, a tick with `full_duty`=1 enters pass-through (`pass_on`=1). This has priority over `light_load`. A tick with `full_duty`=0 returns to PWM.
- R11: At most one of `pwm_en`, `pass_on`, `ps_mode`, `ov_lock` is 1. `burst_en` and `burst_hs` are 1 only with `ps_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enable; low forces idle |
| cyc_tick | input | 1 | One-clock pulse per switching period |
| below_tgt | input | 1 | Output below target |
| above_hi | input | 1 | Output above target +2.5 % |
| below_lo | input | 1 | Output below target −2 % |
| over_ov | input | 1 | Output above target +15 % |
| light_load | input | 1 | Load below power-save threshold |
| ps_ilim | input | 1 | Power-save current limit reached |
| peak_hit | input | 1 | Burst pulse peak inductor current reached |
| full_duty | input | 1 | Required duty cycle near 100 % |
| pwm_en | output | 1 | Fixed-frequency PWM switching enabled |
| pass_on | output | 1 | Hold high-side switch continuously on |
| ps_mode | output | 1 | Power-save mode active |
| burst_en | output | 1 | Burst gate open |
| burst_hs | output | 1 | High-side on within a burst pulse |
| ov_lock | output | 1 | Over-voltage drive lockout |

## Verification
The assertions check the following on every clock:
- the one-hot mode encoding;
- that bursts occur only in power-save;
- the immediate over-voltage lockout and its hold until the −2 % flag;
- the all-zero outputs while disabled;
- that no mode change happens between ticks.

The ordering of transitions can only be shown by the bench's scenarios. These include:
- a burst started by undershoot and ended by either the +2.5 % flag or the current limit;
- the −2 % flag beating a burst start;
- pass-through beating light load;
- a tick that coincides with peak current;
- a reset in the middle of a burst.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic [2:0] {
        M_IDLE     = 3'd0,
        M_PWM      = 3'd1,
        M_PASS     = 3'd2,
        M_PS_WAIT  = 3'd3,
        M_PS_BURST = 3'd4,
        M_OV_LOCK  = 3'd5
    } mode_e;

    typedef struct packed {
        logic full_duty;
        logic peak_hit;
        logic ps_ilim;
        logic light_load;
        logic over_ov;
        logic below_lo;
        logic above_hi;
        logic below_tgt;
    } flags_t;

endpackage

// File: rtl/buck_mode_next.sv
module buck_mode_next
    import buck_mode_pkg::*;
(
    input  mode_e  cur,
    input  logic   enable,
    input  logic   tick,
    input  flags_t fl,
    output mode_e  nxt
);
    always_comb begin
        nxt = cur;
        if (!enable) begin
            nxt = M_IDLE;                       // R1: disable acts at once
        end else if (fl.over_ov && cur != M_OV_LOCK) begin
            nxt = M_OV_LOCK;                    // R8: lockout outranks everything
        end else if (tick) begin
            unique case (cur)
                M_IDLE:     nxt = M_PWM;
                M_PWM: begin
                    if (fl.full_duty)       nxt = M_PASS;     // R10
                    else if (fl.light_load) nxt = M_PS_WAIT;  // R3
                end
                M_PASS: begin
                    if (!fl.full_duty)      nxt = M_PWM;
                end
                M_PS_WAIT: begin
                    if (fl.below_lo)        nxt = M_PWM;      // R7
                    else if (fl.below_tgt)  nxt = M_PS_BURST; // R4
                end
                M_PS_BURST: begin
                    if (fl.below_lo)                    nxt = M_PWM;     // R7
                    else if (fl.above_hi || fl.ps_ilim) nxt = M_PS_WAIT; // R5
                end
                M_OV_LOCK: begin
                    if (fl.below_lo && !fl.over_ov) nxt = M_PWM;      // R9
                end
                default:    nxt = M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/buck_burst_pulse.sv
module buck_burst_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stay_burst,
    input  logic peak_hit,
    output logic hs_on
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hs_on <= 1'b0;
        else if (!stay_burst) hs_on <= 1'b0;
        else if (tick)       hs_on <= 1'b1;   // R6: new pulse each period
        else if (peak_hit)   hs_on <= 1'b0;   // R6: peak ends the pulse
    end
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
    import buck_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_tick,
    input  logic below_tgt,
    input  logic above_hi,
    input  logic below_lo,
    input  logic over_ov,
    input  logic light_load,
    input  logic ps_ilim,
    input  logic peak_hit,
    input  logic full_duty,
    output logic pwm_en,
    output logic pass_on,
    output logic ps_mode,
    output logic burst_en,
    output logic burst_hs,
    output logic ov_lock
);
    mode_e  state;
    mode_e  state_nxt;
    flags_t flags;
    logic   hs_q;

    assign flags = '{full_duty:  full_duty,
                     peak_hit:   peak_hit,
                     ps_ilim:    ps_ilim,
                     light_load: light_load,
                     over_ov:    over_ov,
                     below_lo:   below_lo,
                     above_hi:   above_hi,
                     below_tgt:  below_tgt};

    buck_mode_next u_next (
        .cur    (state),
        .enable (enable),
        .tick   (cyc_tick),
        .fl     (flags),
        .nxt    (state_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= state_nxt;
    end

    buck_burst_pulse u_pulse (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cyc_tick),
        .stay_burst (state_nxt == M_PS_BURST),
        .peak_hit   (peak_hit),
        .hs_on      (hs_q)
    );

    always_comb begin
        pwm_en   = 1'b0;
        pass_on  = 1'b0;
        ps_mode  = 1'b0;
        burst_en = 1'b0;
        burst_hs = 1'b0;
        ov_lock  = 1'b0;
        unique case (state)
            M_IDLE:     ;
            M_PWM:      pwm_en  = 1'b1;
            M_PASS:     pass_on = 1'b1;
            M_PS_WAIT:  ps_mode = 1'b1;
            M_PS_BURST: begin
                ps_mode  = 1'b1;
                burst_en = 1'b1;
                burst_hs = hs_q;
            end
            M_OV_LOCK:  ov_lock = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/buck_mode_checker.sv
module buck_mode_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cyc_tick,
    input logic below_lo,
    input logic over_ov,
    input logic pwm_en,
    input logic pass_on,
    input logic ps_mode,
    input logic burst_en,
    input logic burst_hs,
    input logic ov_lock
);
    a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !(pwm_en || pass_on || ps_mode || burst_en || burst_hs || ov_lock));

    a_r2_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !over_ov && !cyc_tick) |=> $stable({pwm_en, pass_on, ps_mode, ov_lock}));

    a_r8_ov_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && over_ov) |=> (ov_lock && !pwm_en && !pass_on && !burst_en && !burst_hs));

    a_r9_ov_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && ov_lock && !below_lo) |=> ov_lock);

    a_r11_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pwm_en, pass_on, ps_mode, ov_lock}));

    a_r11_burst_in_ps: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_en || burst_hs) |-> ps_mode);

    a_r6_pulse_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        burst_hs |-> burst_en);
endmodule

bind buck_mode_ctrl buck_mode_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .cyc_tick (cyc_tick),
    .below_lo (below_lo),
    .over_ov  (over_ov),
    .pwm_en   (pwm_en),
    .pass_on  (pass_on),
    .ps_mode  (ps_mode),
    .burst_en (burst_en),
    .burst_hs (burst_hs),
    .ov_lock  (ov_lock)
);

// File: tb/test_buck_mode_ctrl.sv
module test_buck_mode_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, cyc_tick = 1'b0;
    logic below_tgt = 1'b0, above_hi = 1'b0, below_lo = 1'b0, over_ov = 1'b0;
    logic light_load = 1'b0, ps_ilim = 1'b0, peak_hit = 1'b0, full_duty = 1'b0;
    logic pwm_en, pass_on, ps_mode, burst_en, burst_hs, ov_lock;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    buck_mode_ctrl i_buck_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_tick(cyc_tick),
        .below_tgt(below_tgt), .above_hi(above_hi), .below_lo(below_lo),
        .over_ov(over_ov), .light_load(light_load), .ps_ilim(ps_ilim),
        .peak_hit(peak_hit), .full_duty(full_duty),
        .pwm_en(pwm_en), .pass_on(pass_on), .ps_mode(ps_mode),
        .burst_en(burst_en), .burst_hs(burst_hs), .ov_lock(ov_lock)
    );

    // Row: [19:16] requirement, [15] enable, [14] tick,
    // [13:6] flags {full,peak,ilim,light,ov,blo,ahi,btgt},
    // [5:0] expected {pwm,pass,ps,burst,hs,ov}
    localparam int NV = 32;
    localparam logic [19:0] VEC [NV] = '{
        {4'd2,  1'b1, 1'b0, 8'b00000000, 6'b000000}, // R2 idle waits for tick
        {4'd2,  1'b1, 1'b1, 8'b00000000, 6'b100000}, // R2 tick enters PWM
        {4'd2,  1'b1, 1'b0, 8'b00010000, 6'b100000}, // R2 no tick, no change
        {4'd3,  1'b1, 1'b1, 8'b00010000, 6'b001000}, // R3 light load
        {4'd4,  1'b1, 1'b1, 8'b00010000, 6'b001000}, // R4 halted, no undershoot
        {4'd4,  1'b1, 1'b1, 8'b00010001, 6'b001110}, // R4 burst start
        {4'd6,  1'b1, 1'b0, 8'b01000000, 6'b001100}, // R6 peak ends pulse
        {4'd6,  1'b1, 1'b1, 8'b00000000, 6'b001110}, // R6 next pulse
        {4'd5,  1'b1, 1'b1, 8'b00000010, 6'b001000}, // R5 +2.5% halts
        {4'd4,  1'b1, 1'b1, 8'b00000001, 6'b001110}, // R4
        {4'd5,  1'b1, 1'b1, 8'b00100000, 6'b001000}, // R5 current limit halts
        {4'd4,  1'b1, 1'b1, 8'b00000001, 6'b001110}, // R4
        {4'd8,  1'b1, 1'b0, 8'b00001000, 6'b000001}, // R8 abort burst, no tick
        {4'd9,  1'b1, 1'b1, 8'b00000000, 6'b000001}, // R9 hold
        {4'd9,  1'b1, 1'b1, 8'b00000001, 6'b000001}, // R9 below target only
        {4'd9,  1'b1, 1'b1, 8'b00000101, 6'b100000}, // R9 -2% releases
        {4'd10, 1'b1, 1'b1, 8'b10000000, 6'b010000}, // R10 pass-through
        {4'd2,  1'b1, 1'b0, 8'b00000000, 6'b010000}, // R2 held until tick
        {4'd10, 1'b1, 1'b1, 8'b00000000, 6'b100000}, // R10 headroom back
        {4'd3,  1'b1, 1'b1, 8'b00010000, 6'b001000}, // R3
        {4'd7,  1'b1, 1'b1, 8'b00010101, 6'b100000}, // R7 -2% beats burst
        {4'd3,  1'b1, 1'b1, 8'b00010000, 6'b001000}, // R3
        {4'd4,  1'b1, 1'b1, 8'b00000001, 6'b001110}, // R4
        {4'd7,  1'b1, 1'b1, 8'b00000101, 6'b100000}, // R7 exit from burst
        {4'd8,  1'b1, 1'b1, 8'b10001000, 6'b000001}, // R8 beats full duty
        {4'd9,  1'b1, 1'b1, 8'b00000101, 6'b100000}, // R9
        {4'd1,  1'b0, 1'b0, 8'b00000000, 6'b000000}, // R1 disable at once
        {4'd1,  1'b0, 1'b1, 8'b00010000, 6'b000000}, // R1 tick ignored
        {4'd1,  1'b0, 1'b0, 8'b00001000, 6'b000000}, // R1 ov ignored
        {4'd8,  1'b1, 1'b0, 8'b00001000, 6'b000001}, // R8 from idle
        {4'd9,  1'b1, 1'b1, 8'b00000101, 6'b100000}, // R9
        {4'd10, 1'b1, 1'b1, 8'b10010000, 6'b010000}  // R10 beats light load
    };

    function automatic logic [5:0] outs();
        return {pwm_en, pass_on, ps_mode, burst_en, burst_hs, ov_lock};
    endfunction

    task automatic check(input int req, input logic [5:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d %s: got %b expected %b", req, tag, outs(), exp);
        end
        checks++;
        if ($countones({pwm_en, pass_on, ps_mode, ov_lock}) > 1) begin
            errors++;   // R11
            $display("FAIL R11 %s: got %b expected at most one mode", tag, outs());
        end
    endtask

    task automatic drive(input logic en, input logic tk, input logic [7:0] f);
        enable = en; cyc_tick = tk;
        {full_duty, peak_hit, ps_ilim, light_load, over_ov, below_lo, above_hi, below_tgt} = f;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, 6'b000000, "in reset");             // R1
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 6'b000000, "after reset");          // R1

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][15], VEC[i][14], VEC[i][13:6]);
            @(negedge clk);
            check(int'(VEC[i][19:16]), VEC[i][5:0], $sformatf("row %0d", i));
        end

        // R10: clearing full duty returns to PWM, then reach a burst
        drive(1'b1, 1'b1, 8'b00010000); @(negedge clk);
        check(10, 6'b100000, "pass exit");
        drive(1'b1, 1'b1, 8'b00010000); @(negedge clk);
        check(3, 6'b001000, "enter power-save");
        drive(1'b1, 1'b1, 8'b00000001); @(negedge clk);
        check(4, 6'b001110, "burst again");
        // R6: tick coinciding with peak keeps the pulse
        drive(1'b1, 1'b1, 8'b01000000); @(negedge clk);
        check(6, 6'b001110, "tick beats peak");
        // R1: reset mid-burst clears everything
        drive(1'b1, 1'b0, 8'b00000000);
        rst_n = 1'b0; #1;
        check(1, 6'b000000, "reset mid-burst");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(2, 6'b000000, "idle after reset, no tick");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule